// File: doc/BRIEF.md
# USB Suspend and Resume Controller

This block holds the power-management control word of a USB full-speed device function. Firmware reaches the word over a simple register bus. The bus has a write strobe with write data. The read data is always valid and shows the current state of the word. The block also takes line-level events from the transceiver and the packet engine: a suspend indication, detected host resume, live bus-reset signaling, and start-of-frame and IN tokens. It turns these into a suspend flag, a resume-drive request, a one-cycle wakeup interrupt and a one-cycle function reset.

The bits of the word do not all follow the same rules. Hardware sets the suspend flag and clears it again. Software may clear the traffic inhibit flag but can never set it. The reset bit starts a reset when written, but it reads back the live state of the bus. Suspend ends in one of two ways. One is a remote wakeup that software ends by writing the resume bit to 0. The other is a host resume, which ends when the interrupt status register is read.

For isochronous IN traffic, the block decides whether a ready packet goes out on the next IN token or waits for a start-of-frame. An IN token that cannot release a packet gets a zero-length reply.

Top module: `usb_pwr_ctrl`

## Requirements
- R1: After reset, `reg_rdata` reads 0x11 (inhibit bit 4 and suspend-enable bit 0 set, all else 0, with `bus_reset_line` low), and every output pulse and `resume_drive` are 0.
- R2: Bit 7 (isochronous hold) and bit 0 (suspend enable) take the written value. Bits 6 and 5 always read 0, whatever is written to them.
- R3: A write with bit 4 = 0 clears the inhibit flag (bit 4). A write with bit 4 = 1 never sets it. While the flag is 1, `line_suspend`, `host_resume`, `in_token` and `sof_token` are ignored.
- R4: A write with bit 3 = 1 makes `func_reset` 1 for exactly the next cycle and sets the inhibit flag. Bit 3 reads back the level of `bus_reset_line`.
- R5: With bit 0 = 1, a `line_suspend` cycle sets the suspend flag (bit 1) on the next edge. With bit 0 = 0, `line_suspend` is ignored.
- R6: Writing bit 2 = 1 while the suspend flag is 1 sets the resume bit (bit 2) and `resume_drive`. Writing bit 2 = 1 while the suspend flag is 0 has no effect, and bit 2 reads 0.
- R7: Writing bit 2 = 0 while the resume bit is 1 clears the resume bit, `resume_drive` and the suspend flag, and gives a `wake_irq` pulse of exactly one cycle.
- R8: A `host_resume` cycle while suspended, followed by an `irq_status_rd` cycle, clears the suspend flag. An `irq_status_rd` with no prior host resume leaves the flag set.
- R9: With bit 7 = 0, an `in_token` while a packet is ready gives `send_pkt` in the next cycle and consumes the packet. An `in_token` with no ready packet gives `send_zlp`.
- R10: With bit 7 = 1, a ready packet is released only after a `sof_token` seen after it became ready. An `in_token` before that gives `send_zlp` and the packet stays ready.
- R11: `send_pkt` and `send_zlp` are one-cycle pulses and are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Current register image |
| bus_reset_line | input | 1 | Reset signaling present on the bus (level) |
| line_suspend | input | 1 | Suspend indication from the line (strobe) |
| host_resume | input | 1 | Host resume signaling detected (strobe) |
| irq_status_rd | input | 1 | Read of the common interrupt status register (strobe) |
| pkt_ready | input | 1 | Isochronous IN packet marked ready (strobe) |
| in_token | input | 1 | IN token received (strobe) |
| sof_token | input | 1 | Start-of-frame token received (strobe) |
| resume_drive | output | 1 | Request to drive resume signaling |
| wake_irq | output | 1 | Wakeup interrupt pulse |
| func_reset | output | 1 | Function reset pulse |
| send_pkt | output | 1 | Send the ready packet |
| send_zlp | output | 1 | Send a zero-length data packet |

## Verification
The assertions assume that every strobe input is high for whole cycles and changes only away from the rising edge. They also assume that `host_resume` is only meaningful while the function is suspended. The bench drives every input just after an edge and holds it for a single cycle. Register writes and line events are spread over separate cycles, so each check has a single cause. The suspend exits are driven in both orders: remote wakeup, then host resume followed by the status read. A status read that is not preceded by a host resume is also driven.

// File: rtl/usb_pwr_pkg.sv
package usb_pwr_pkg;
  localparam int REG_W    = 8;
  localparam int B_ISO    = 7;
  localparam int B_INH    = 4;
  localparam int B_RST    = 3;
  localparam int B_RES    = 2;
  localparam int B_SUSP   = 1;
  localparam int B_EN     = 0;
  localparam logic [REG_W-1:0] RESET_IMAGE = 8'h11;

  function automatic logic [REG_W-1:0] pack_image(
    input logic iso, input logic inh, input logic rst_line,
    input logic res, input logic susp, input logic en);
    logic [REG_W-1:0] img;
    img         = '0;
    img[B_ISO]  = iso;
    img[B_INH]  = inh;
    img[B_RST]  = rst_line;
    img[B_RES]  = res;
    img[B_SUSP] = susp;
    img[B_EN]   = en;
    return img;
  endfunction

  function automatic logic next_inhibit(
    input logic cur, input logic wr, input logic [REG_W-1:0] wd);
    if (wr && wd[B_RST])      return 1'b1;
    else if (wr && !wd[B_INH]) return 1'b0;
    else                       return cur;
  endfunction
endpackage

// File: rtl/pwr_inhibit_ctl.sv
module pwr_inhibit_ctl
  import usb_pwr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic             inhibit,
  output logic             func_reset
);
  logic force_rst;
  assign force_rst = wr && wdata[B_RST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inhibit    <= 1'b1;
      func_reset <= 1'b0;
    end else begin
      inhibit    <= next_inhibit(inhibit, wr, wdata);
      func_reset <= force_rst;
    end
  end

  // R3: inhibit only rises through a forced reset
  a_r3_inhibit_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inhibit) |-> $past(wr && wdata[B_RST]));
  // R4: reset pulse follows a reset write
  a_r4_reset_cause: assert property (@(posedge clk) disable iff (!rst_n)
    func_reset |-> $past(wr && wdata[B_RST]));
  a_r4_reset_inhibits: assert property (@(posedge clk) disable iff (!rst_n)
    func_reset |-> inhibit);
endmodule

// File: rtl/pwr_susp_ctl.sv
module pwr_susp_ctl
  import usb_pwr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             susp_en,
  input  logic             inhibit,
  input  logic             line_suspend,
  input  logic             host_resume,
  input  logic             irq_status_rd,
  output logic             susp,
  output logic             resume,
  output logic             wake_irq
);
  logic hr_pend;
  logic start_resume, end_resume, susp_set, hr_seen, hr_clear;

  assign start_resume = wr && wdata[B_RES] && susp && !resume;
  assign end_resume   = wr && !wdata[B_RES] && resume;
  assign susp_set     = line_suspend && susp_en && !inhibit && !susp;
  assign hr_seen      = host_resume && susp && !resume && !inhibit;
  assign hr_clear     = irq_status_rd && hr_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      susp     <= 1'b0;
      resume   <= 1'b0;
      hr_pend  <= 1'b0;
      wake_irq <= 1'b0;
    end else begin
      wake_irq <= 1'b0;
      if (end_resume) begin
        resume   <= 1'b0;
        susp     <= 1'b0;
        hr_pend  <= 1'b0;
        wake_irq <= 1'b1;
      end else if (hr_clear) begin
        susp    <= 1'b0;
        hr_pend <= 1'b0;
      end else begin
        if (start_resume) resume  <= 1'b1;
        if (susp_set)     susp    <= 1'b1;
        if (hr_seen)      hr_pend <= 1'b1;
      end
    end
  end

  // R5: suspend is entered only from an accepted line indication
  a_r5_susp_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susp) |-> $past(line_suspend && susp_en && !inhibit));
  // R6: resume drive only starts from suspend
  a_r6_resume_from_susp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resume) |-> $past(susp));
  // R7: interrupt coincides with leaving suspend and resume
  a_r7_irq_exit: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> (!susp && !resume));
  a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |=> !wake_irq);
  // R8: a silent suspend exit needs a status read
  a_r8_silent_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(susp) && !wake_irq) |-> $past(irq_status_rd));
endmodule

// File: rtl/pwr_iso_gate.sv
module pwr_iso_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic iso_hold,
  input  logic inhibit,
  input  logic pkt_ready,
  input  logic in_token,
  input  logic sof_token,
  output logic send_pkt,
  output logic send_zlp
);
  logic ready, armed;
  logic tok_in, tok_sof, release_ok;

  assign tok_in     = in_token && !inhibit;
  assign tok_sof    = sof_token && !inhibit;
  assign release_ok = ready && (!iso_hold || armed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready    <= 1'b0;
      armed    <= 1'b0;
      send_pkt <= 1'b0;
      send_zlp <= 1'b0;
    end else begin
      send_pkt <= 1'b0;
      send_zlp <= 1'b0;
      if (tok_in) begin
        if (release_ok) begin
          send_pkt <= 1'b1;
          ready    <= 1'b0;
          armed    <= 1'b0;
        end else begin
          send_zlp <= 1'b1;
        end
      end
      if (pkt_ready) begin
        ready <= 1'b1;
        armed <= 1'b0;
      end else if (tok_sof && ready && !(tok_in && release_ok)) begin
        armed <= 1'b1;
      end
    end
  end

  // R11: replies are exclusive
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(send_pkt && send_zlp));
  // R3/R11: every reply answers an accepted token
  a_r11_token_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (send_pkt || send_zlp) |-> $past(in_token && !inhibit));
  // R10: held packet needs a frame start first
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (send_pkt && $past(iso_hold)) |-> $past(armed));
endmodule

// File: rtl/usb_pwr_ctrl.sv
module usb_pwr_ctrl
  import usb_pwr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             bus_reset_line,
  input  logic             line_suspend,
  input  logic             host_resume,
  input  logic             irq_status_rd,
  input  logic             pkt_ready,
  input  logic             in_token,
  input  logic             sof_token,
  output logic             resume_drive,
  output logic             wake_irq,
  output logic             func_reset,
  output logic             send_pkt,
  output logic             send_zlp
);
  logic iso_hold, susp_en, inhibit, susp, resume;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iso_hold <= RESET_IMAGE[B_ISO];
      susp_en  <= RESET_IMAGE[B_EN];
    end else if (reg_wr) begin
      iso_hold <= reg_wdata[B_ISO];
      susp_en  <= reg_wdata[B_EN];
    end
  end

  pwr_inhibit_ctl u_inh (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
    .inhibit(inhibit), .func_reset(func_reset)
  );

  pwr_susp_ctl u_susp (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
    .susp_en(susp_en), .inhibit(inhibit), .line_suspend(line_suspend),
    .host_resume(host_resume), .irq_status_rd(irq_status_rd),
    .susp(susp), .resume(resume), .wake_irq(wake_irq)
  );

  pwr_iso_gate u_iso (
    .clk(clk), .rst_n(rst_n), .iso_hold(iso_hold), .inhibit(inhibit),
    .pkt_ready(pkt_ready), .in_token(in_token), .sof_token(sof_token),
    .send_pkt(send_pkt), .send_zlp(send_zlp)
  );

  assign resume_drive = resume;
  assign reg_rdata    = pack_image(iso_hold, inhibit, bus_reset_line,
                                   resume, susp, susp_en);

  // R2: unused bits stay clear
  a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[6:5] == 2'b00);
  // R6: resume drive implies suspend
  a_r6_drive_in_susp: assert property (@(posedge clk) disable iff (!rst_n)
    resume_drive |-> susp);
endmodule

// File: tb/test_usb_pwr_ctrl.sv
module test_usb_pwr_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       bus_reset_line = 1'b0, line_suspend = 1'b0, host_resume = 1'b0;
  logic       irq_status_rd = 1'b0, pkt_ready = 1'b0, in_token = 1'b0, sof_token = 1'b0;
  logic       resume_drive, wake_irq, func_reset, send_pkt, send_zlp;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  usb_pwr_ctrl i_usb_pwr_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .bus_reset_line(bus_reset_line),
    .line_suspend(line_suspend), .host_resume(host_resume),
    .irq_status_rd(irq_status_rd), .pkt_ready(pkt_ready),
    .in_token(in_token), .sof_token(sof_token), .resume_drive(resume_drive),
    .wake_irq(wake_irq), .func_reset(func_reset), .send_pkt(send_pkt),
    .send_zlp(send_zlp)
  );

  // expected image built from the bit layout in the requirements
  function automatic logic [7:0] img(input bit iso, input bit inh, input bit rl,
                                     input bit res, input bit sus, input bit en);
    return {iso, 2'b00, inh, rl, res, sus, en};
  endfunction

  // {written value, expected read-back}, from reset state
  localparam logic [15:0] VEC [6] = '{
    16'h00_00, 16'h10_00, 16'h81_81, 16'hE1_81, 16'h05_01, 16'h01_01
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    step();
    reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog got=%0d exp=<5000", cyc);
      finish_run();
    end
  end

  initial begin
    step(); step();
    // R1: reset image and idle outputs
    chk("R1 image", reg_rdata, 8'h11);
    chk("R1 outputs", {3'b0, resume_drive, wake_irq, func_reset, send_pkt, send_zlp}, 8'h00);
    rst_n = 1'b1;
    step();
    chk("R1 image after release", reg_rdata, 8'h11);

    // R2 R3 R6: table of writes and read-backs
    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][15:8]);
      chk($sformatf("R2/R3/R6 vec%0d", i), reg_rdata, VEC[i][7:0]);
    end

    // R4: bit 3 reflects the line
    bus_reset_line = 1'b1; #1;
    chk("R4 line read", reg_rdata, img(0,0,1,0,0,1));
    bus_reset_line = 1'b0; #1;

    // R5 R6 R7: suspend then remote wakeup
    line_suspend = 1'b1; step(); line_suspend = 1'b0;
    chk("R5 suspend set", reg_rdata, img(0,0,0,0,1,1));
    wr(8'h05);
    chk("R6 resume set", reg_rdata, img(0,0,0,1,1,1));
    chk("R6 drive on", {7'b0, resume_drive}, 8'h01);
    wr(8'h01);
    chk("R7 irq pulse", {7'b0, wake_irq}, 8'h01);
    chk("R7 exit image", reg_rdata, img(0,0,0,0,0,1));
    chk("R7 drive off", {7'b0, resume_drive}, 8'h00);
    step();
    chk("R7 irq single cycle", {7'b0, wake_irq}, 8'h00);

    // R5: disabled detection ignores the line
    wr(8'h00);
    line_suspend = 1'b1; step(); line_suspend = 1'b0;
    chk("R5 disabled", reg_rdata, 8'h00);
    wr(8'h01);

    // R8: host resume exit ordering
    line_suspend = 1'b1; step(); line_suspend = 1'b0;
    irq_status_rd = 1'b1; step(); irq_status_rd = 1'b0;
    chk("R8 read without resume", reg_rdata, img(0,0,0,0,1,1));
    host_resume = 1'b1; step(); host_resume = 1'b0;
    chk("R8 still suspended", reg_rdata, img(0,0,0,0,1,1));
    irq_status_rd = 1'b1; step(); irq_status_rd = 1'b0;
    chk("R8 exit on read", reg_rdata, img(0,0,0,0,0,1));
    chk("R8 no irq", {7'b0, wake_irq}, 8'h00);

    // R9 R11: immediate release
    in_token = 1'b1; step(); in_token = 1'b0;
    chk("R9 empty zlp", {6'b0, send_pkt, send_zlp}, 8'h01);
    pkt_ready = 1'b1; step(); pkt_ready = 1'b0;
    in_token = 1'b1; step(); in_token = 1'b0;
    chk("R9 packet sent", {6'b0, send_pkt, send_zlp}, 8'h02);
    step();
    chk("R11 single cycle", {6'b0, send_pkt, send_zlp}, 8'h00);

    // R10: held until frame start
    wr(8'h81);
    pkt_ready = 1'b1; step(); pkt_ready = 1'b0;
    in_token = 1'b1; step(); in_token = 1'b0;
    chk("R10 early in zlp", {6'b0, send_pkt, send_zlp}, 8'h01);
    sof_token = 1'b1; step(); sof_token = 1'b0;
    in_token = 1'b1; step(); in_token = 1'b0;
    chk("R10 release after sof", {6'b0, send_pkt, send_zlp}, 8'h02);

    // R4: forced reset pulse and inhibit
    wr(8'h89);
    chk("R4 pulse", {7'b0, func_reset}, 8'h01);
    chk("R4 inhibit set", reg_rdata, img(1,1,0,0,0,1));
    step();
    chk("R4 pulse single", {7'b0, func_reset}, 8'h00);

    // R3: inhibit ignores line events and tokens
    line_suspend = 1'b1; step(); line_suspend = 1'b0;
    chk("R3 suspend ignored", reg_rdata, img(1,1,0,0,0,1));
    sof_token = 1'b1; pkt_ready = 1'b1; step(); sof_token = 1'b0; pkt_ready = 1'b0;
    in_token = 1'b1; step(); in_token = 1'b0;
    chk("R3 token ignored", {6'b0, send_pkt, send_zlp}, 8'h00);
    wr(8'h01);
    chk("R3 cleared", reg_rdata, img(0,0,0,0,0,1));
    in_token = 1'b1; step(); in_token = 1'b0;
    chk("R3 packet kept", {6'b0, send_pkt, send_zlp}, 8'h02);

    finish_run();
  end
endmodule